// File: doc/BRIEF.md
# Serial Gain-Word Control Port

This block is the device-side serial control port for one variable-gain channel. A host opens a frame by raising `frameIn`, then clocks bits on `sclkIn` while presenting them on `sdiIn`. The first bit clocked in a frame sets the direction. With a 1 the next bits are captured as a new gain word. With a 0 the stored gain word is shifted back out on `sdoOut`. Bits travel least-significant first in both directions.

The serial clock, frame and data pins are brought into the system clock domain through two-flop synchronizers. Their edges are then detected and used as single-cycle enables, so the serial clock has to run well below the system clock. Inputs are sampled on detected rising edges of the serial clock. The output changes on detected falling edges. The stored word drives `gainOut` in parallel for the gain stage downstream. That output changes only when a complete write frame is accepted.

Top module: `gain_serial_port`

## Requirements
- R1: After reset, `gainOut` is 0 and `sdoOut` is 0.
- R2: The frame is active while `frameIn` is high. The first `sclkIn` rising edge of a frame samples the direction: 1 selects write and 0 selects read. A read frame never alters `gainOut`.
- R3: In a write frame, the bits sampled on the following `sclkIn` rising edges form the new word least-significant bit first. Data bit k (counting from 0) lands in `gainOut[k]`.
- R4: A write is committed when `frameIn` falls, and only if exactly GAIN_W data bits followed the direction bit. A frame with fewer or more data bits leaves `gainOut` unchanged.
- R5: In a read frame, the falling `sclkIn` edge that follows the direction bit drives gain bit 0 on `sdoOut`. Each later falling edge drives the next higher bit. Each bit is held until the next falling edge.
- R6: `sdoOut` is 0 whenever no read bit is being presented. This covers idle time, write frames, the falling edge after the most significant bit has been shifted out, and the time after the frame closes.
- R7: Activity on `sclkIn` and `sdiIn` while `frameIn` is low has no effect on `gainOut` or `sdoOut`.
- R8: `gainOut` holds its value during a frame and changes in a single cycle at commit. It never shows a partially shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host, asynchronous |
| frameIn | input | 1 | Frame enable, high for the duration of a transaction |
| sdiIn | input | 1 | Serial data in, direction bit first |
| sdoOut | output | 1 | Serial data out, gain word least-significant bit first |
| gainOut | output | GAIN_W | Committed gain word |

## Verification
On every cycle, the assertions check the following. The gain register moves only on a commit strobe. The output bit changes only on a shift or clear strobe, and it is low after a clear. The direction flag stays fixed once the first bit of a frame has been taken. The bit counter is emptied after each frame closes. Only the bench scenarios can show the rest: the end-to-end bit order, the rule that rejects short and long frames, and that serial activity outside a frame has no effect. The bench compares these against its own model of the committed word and of the expected read-back bit queue.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  // Single-cycle strobes from the control to the datapath
  typedef struct packed {
    logic shiftIn;   // take synchronized data bit into the write shifter
    logic commit;    // copy write shifter into the gain register
    logic loadRd;    // copy gain register into the read shifter
    logic shiftOut;  // present next read bit on the serial output
    logic clearOut;  // force the serial output low
  } gspStrobe_t;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
  import gsp_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       frameIn,
  input  logic       sdiIn,
  output gspStrobe_t strobe,
  output logic       sdiBit
);
  localparam int CNTW = $clog2(GAIN_W + 3);
  localparam int OUTW = $clog2(GAIN_W + 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(GAIN_W + 1);
  localparam logic [CNTW-1:0] CNT_SAT  = CNTW'(GAIN_W + 2);
  localparam logic [OUTW-1:0] OUT_LAST = OUTW'(GAIN_W);

  logic [2:0] syncd;
  logic sclkS, frameS, sdiS;
  logic sclkPrev, framePrev;
  logic sclkRise, sclkFall, frameClose;
  logic [CNTW-1:0] bitCnt;
  logic [OUTW-1:0] outCnt;
  logic isRead, readActive;

  gsp_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sdiIn, frameIn, sclkIn}),
    .syncOut(syncd)
  );

  assign sclkS  = syncd[0];
  assign frameS = syncd[1];
  assign sdiS   = syncd[2];
  assign sdiBit = sdiS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      framePrev <= 1'b0;
    end else begin
      sclkPrev  <= sclkS;
      framePrev <= frameS;
    end
  end

  assign sclkRise   = sclkS & ~sclkPrev;
  assign sclkFall   = ~sclkS & sclkPrev;
  assign frameClose = ~frameS & framePrev;

  always_comb begin
    strobe.shiftIn  = sclkRise & frameS & (bitCnt != '0) & ~isRead;
    strobe.loadRd   = sclkRise & frameS & (bitCnt == '0) & ~sdiS;
    strobe.shiftOut = sclkFall & frameS & readActive & (outCnt < OUT_LAST);
    strobe.clearOut = (sclkFall & frameS & readActive & (outCnt >= OUT_LAST))
                    | frameClose;
    strobe.commit   = frameClose & ~isRead & (bitCnt == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      outCnt     <= '0;
      isRead     <= 1'b0;
      readActive <= 1'b0;
    end else if (!frameS) begin
      bitCnt     <= '0;
      outCnt     <= '0;
      readActive <= 1'b0;
    end else begin
      if (sclkRise) begin
        if (bitCnt == '0) isRead <= ~sdiS;
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.loadRd) begin
        readActive <= 1'b1;
        outCnt     <= '0;
      end else if (strobe.shiftOut) begin
        outCnt <= outCnt + 1'b1;
      end
    end
  end

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != '0) |=> $stable(isRead));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameClose |=> (bitCnt == '0));
endmodule

// File: rtl/gsp_datapath.sv
module gsp_datapath
  import gsp_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gspStrobe_t        strobe,
  input  logic              sdiBit,
  output logic [GAIN_W-1:0] gainOut,
  output logic              sdoOut
);
  logic [GAIN_W-1:0] wrShift, rdShift, gainReg;
  logic sdoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrShift <= '0;
      gainReg <= '0;
    end else begin
      if (strobe.shiftIn) wrShift <= {sdiBit, wrShift[GAIN_W-1:1]};
      if (strobe.commit)  gainReg <= wrShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
      sdoReg  <= 1'b0;
    end else begin
      if (strobe.loadRd) begin
        rdShift <= gainReg;
      end else if (strobe.shiftOut) begin
        sdoReg  <= rdShift[0];
        rdShift <= {1'b0, rdShift[GAIN_W-1:1]};
      end
      if (strobe.clearOut) sdoReg <= 1'b0;
    end
  end

  assign gainOut = gainReg;
  assign sdoOut  = sdoReg;

  // R8
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(gainReg));

  // R6
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearOut |=> !sdoReg);

  // R5
  sdo_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftOut || strobe.clearOut) |=> $stable(sdoReg));
endmodule

// File: rtl/gain_serial_port.sv
module gain_serial_port
  import gsp_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              frameIn,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic [GAIN_W-1:0] gainOut
);
  gspStrobe_t strobe;
  logic sdiBit;

  gsp_ctrl #(.GAIN_W(GAIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkIn(sclkIn), .frameIn(frameIn), .sdiIn(sdiIn),
    .strobe(strobe), .sdiBit(sdiBit)
  );

  gsp_datapath #(.GAIN_W(GAIN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .sdiBit(sdiBit),
    .gainOut(gainOut), .sdoOut(sdoOut)
  );
endmodule

// File: tb/test_gain_serial_port.sv
module test_gain_serial_port;
  localparam int W = 6;
  localparam int H = 6;   // system clocks per serial half period

  logic clk = 1'b0, rstN = 1'b0;
  logic sclkIn = 1'b0, frameIn = 1'b0, sdiIn = 1'b0;
  logic sdoOut;
  logic [W-1:0] gainOut;

  int nChecks = 0, nFails = 0;
  int modelGain = 0;
  bit chkEn = 1'b0;
  bit finished = 1'b0;
  bit expBits[$];

  always #4 clk = ~clk;

  gain_serial_port #(.GAIN_W(W)) i_gain_serial_port (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .frameIn(frameIn),
    .sdiIn(sdiIn), .sdoOut(sdoOut), .gainOut(gainOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: per-clock comparison of the parallel output against the model
  always @(negedge clk) begin
    if (chkEn && !finished)
      check(gainOut == W'(modelGain), "R8 gainOut vs model", gainOut, modelGain);
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic closeFrame(input bit commitOk, input int word);
    frameIn = 1'b0;
    chkEn = 1'b0;
    waitN(H);
    if (commitOk) modelGain = word;
    chkEn = 1'b1;
    check(sdoOut == 1'b0, "R6 sdo low after frame", sdoOut, 0);
  endtask

  // Write frame: direction 1, then nData bits of word, LSB first
  task automatic writeFrame(input int word, input int nData);
    frameIn = 1'b1;
    waitN(H);
    for (int i = 0; i <= nData; i++) begin
      sdiIn = (i == 0) ? 1'b1 : ((word >> (i - 1)) & 1);
      waitN(H);
      sclkIn = 1'b1;
      waitN(H);
      sclkIn = 1'b0;
      waitN(H);
      check(sdoOut == 1'b0, "R6 sdo low during write", sdoOut, 0);
    end
    closeFrame(nData == W, word);  // R3 R4
  endtask

  // Read frame: direction 0, then W further clocks with sdi noise
  task automatic readFrame();
    for (int k = 0; k < W; k++) expBits.push_back((modelGain >> k) & 1);
    frameIn = 1'b1;
    waitN(H);
    for (int i = 0; i <= W; i++) begin
      sdiIn = (i == 0) ? 1'b0 : 1'b1;
      waitN(H);
      sclkIn = 1'b1;
      waitN(H);
      sclkIn = 1'b0;
      waitN(H - 1);
      if (i < W) begin
        bit e = expBits.pop_front();
        check(sdoOut == e, "R5 read bit", sdoOut, e);
      end else begin
        check(sdoOut == 1'b0, "R6 sdo low after last bit", sdoOut, 0);
      end
      waitN(1);
    end
    closeFrame(1'b0, 0);
    check(gainOut == W'(modelGain), "R2 read leaves gain", gainOut, modelGain);
  endtask

  initial begin
    waitN(3);
    check(gainOut == '0, "R1 reset gain", gainOut, 0);
    check(sdoOut == 1'b0, "R1 reset sdo", sdoOut, 0);
    rstN = 1'b1;
    waitN(4);
    chkEn = 1'b1;

    writeFrame(6'h2A, W);                       // R3
    check(gainOut == 6'h2A, "R3 write 0x2A", gainOut, 6'h2A);
    readFrame();                                // R5 R2
    writeFrame(6'h3F, W);
    check(gainOut == 6'h3F, "R3 write 0x3F", gainOut, 6'h3F);
    writeFrame(6'h01, W);
    check(gainOut == 6'h01, "R3 write LSB only", gainOut, 6'h01);
    readFrame();
    writeFrame(6'h15, W - 1);                   // R4 short
    check(gainOut == 6'h01, "R4 short frame", gainOut, 6'h01);
    writeFrame(6'h15, W + 1);                   // R4 long
    check(gainOut == 6'h01, "R4 long frame", gainOut, 6'h01);
    writeFrame(6'h29, W + 3);                   // R4 much longer
    check(gainOut == 6'h01, "R4 overlong frame", gainOut, 6'h01);

    // R7: serial activity with frame low
    for (int i = 0; i < 8; i++) begin
      sdiIn = i[0];
      waitN(H);
      sclkIn = ~sclkIn;
      waitN(H);
      check(sdoOut == 1'b0, "R7 sdo unaffected", sdoOut, 0);
    end
    sclkIn = 1'b0;
    waitN(H);
    check(gainOut == 6'h01, "R7 gain unaffected", gainOut, 6'h01);

    writeFrame(6'h36, W);
    check(gainOut == 6'h36, "R3 write 0x36", gainOut, 6'h36);
    readFrame();
    writeFrame(0, W);
    check(gainOut == 6'h00, "R3 write zero", gainOut, 0);
    readFrame();

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule